// File: doc/BRIEF.md
# Memory-to-Memory Transfer Sequencer

This block runs the data movement of a single transfer channel once the channel's settings have been captured. A one-cycle start pulse latches a source address, a destination address, a unit count, a unit width (halfword or word) and a step code for each address. The sequencer then moves one unit at a time. For each unit it issues a read at the source, issues a write at the destination in the next cycle, and then waits out the rest of that unit's cycle cost. It then steps both addresses and lowers the count. When the count reaches zero it spends one more cycle on a completion step and returns to idle.

The cycle cost of a unit is 2 plus the wait states of the source region and of the destination region. The wait states are looked up in one of four tables, chosen by access width and by whether the unit is the first of the burst. The first unit pays 2 extra cycles when either address lies below the cartridge regions. The busy output is meant to hold the processor off the bus for the whole burst. The running addresses and count are always visible, so a surrounding controller can park a burst and restart it later.

Top module: `dma_burst_seq`

## Requirements
- R1: While reset is asserted and after it is released, busy, done, mem_rd and mem_wr are low and bus_latch is zero.
- R2: Each unit produces exactly one cycle with mem_rd high at the source address, followed in the next cycle by exactly one cycle with mem_wr high at the destination address. mem_wide high means a 4-byte unit and low means a 2-byte unit. A burst of N units produces N reads.
- R3: Step code 0 adds one unit width to an address after each unit. Code 1 subtracts one unit width. Code 2 leaves the address unchanged. Code 3 adds one unit width.
- R4: On the first unit of a burst, both addresses are aligned before use. For 2-byte units bit 0 is cleared, and for 4-byte units bits 1:0 are cleared.
- R5: The number of cycles from one unit's read to the next read (or to done, for the last unit) is 2 + ws[src region] + ws[dst region]. The region is address bits 27:24. Entry i of a table occupies bits [4i+3:4i]. The first unit uses ws_first16 or ws_first32 and later units use ws_seq16 or ws_seq32, chosen by width.
- R6: The first unit costs 2 more cycles when the source region or the destination region is below 8.
- R7: For 4-byte units, mem_wdata and then bus_latch equal mem_rdata. For 2-byte units, memory returns the halfword in mem_rdata[15:0], and both mem_wdata and bus_latch carry that halfword in both halves.
- R8: busy rises in the cycle after an accepted start and falls after done. done is high for one cycle, in the cycle where the next read would have been.
- R9: cur_src, cur_dst and cur_cnt show the stepped addresses and remaining count after each unit. cur_cnt decrements on each write and ends at 0.
- R10: With destination step code 3, cur_dst returns to the latched destination address when the burst completes.
- R11: A start with count 0 makes no memory access and raises done in the cycle after the start.
- R12: A start pulse while busy is high is ignored. The running burst keeps its settings, and no second burst follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Latch settings and begin a burst (idle only) |
| src_addr | input | 28 | Starting source byte address |
| dst_addr | input | 28 | Starting destination byte address |
| unit_count | input | 17 | Number of units to move |
| wide | input | 1 | 1 = 4-byte units, 0 = 2-byte units |
| src_step | input | 2 | Source step code |
| dst_step | input | 2 | Destination step code |
| ws_first16 | input | 64 | First-unit halfword wait states, 16 regions x 4 bits |
| ws_first32 | input | 64 | First-unit word wait states |
| ws_seq16 | input | 64 | Later-unit halfword wait states |
| ws_seq32 | input | 64 | Later-unit word wait states |
| mem_rdata | input | 32 | Read data, valid in the cycle after mem_rd |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_addr | output | 28 | Access address |
| mem_wide | output | 1 | Access width, 1 = word |
| mem_wdata | output | 32 | Write data |
| bus_latch | output | 32 | Last data moved, halfwords mirrored |
| busy | output | 1 | Burst in progress, processor held off |
| done | output | 1 | One-cycle completion pulse |
| cur_src | output | 28 | Running source address |
| cur_dst | output | 28 | Running destination address |
| cur_cnt | output | 17 | Remaining units |

## Verification
A wrong first-unit flag or a wrong region decode shows up as a shifted read cycle. The error appears at the very next read, or at done for the last unit, because the bench times every read against its own cost model. A wrong step or alignment shows up as a wrong mem_addr on the next access, and it shows again in cur_src and cur_dst after the burst. Lost or repeated count state shows up as an extra or missing read, or as a done pulse in the wrong cycle. A wrong lane choice in the data path shows up in mem_wdata in the same write cycle and in bus_latch one cycle later.

// File: rtl/dma_seq_pkg.sv
// Shared types for the transfer sequencer.
// Assumes: step codes are two bits wide, and code 3 is the incrementing
// code whose destination reloads at burst end.
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_WRITE,
        ST_WAIT,
        ST_DONE
    } seq_state_t;

    localparam logic [1:0] STEP_INC = 2'd0;
    localparam logic [1:0] STEP_DEC = 2'd1;
    localparam logic [1:0] STEP_FIX = 2'd2;
    localparam logic [1:0] STEP_RLD = 2'd3;

endpackage

// File: rtl/dma_addr_unit.sv
// Address unit: aligns a running address on the first unit of a burst and
// forms the address that the next unit will use.
// Assumes: the unit width is 2 or 4 bytes, and stepping wraps modulo 2^ADDR_W.
module dma_addr_unit
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W = 28
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        mode_i,
    input  logic              wide_i,
    input  logic              first_i,
    output logic [ADDR_W-1:0] addr_eff_o,
    output logic [ADDR_W-1:0] addr_next_o
);

    localparam logic [ADDR_W-1:0] ALIGN16 = ~ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ALIGN32 = ~ADDR_W'(3);

    logic [ADDR_W-1:0] step_bytes;

    // Clear the low bits on the first unit only.
    always_comb begin
        if (first_i) begin
            addr_eff_o = addr_i & (wide_i ? ALIGN32 : ALIGN16);
        end else begin
            addr_eff_o = addr_i;
        end
    end

    // Apply the per-unit step chosen by the step code.
    always_comb begin
        step_bytes = wide_i ? ADDR_W'(4) : ADDR_W'(2);
        case (mode_i)
            STEP_INC: addr_next_o = addr_eff_o + step_bytes;
            STEP_DEC: addr_next_o = addr_eff_o - step_bytes;
            STEP_RLD: addr_next_o = addr_eff_o + step_bytes;
            default:  addr_next_o = addr_eff_o;
        endcase
    end

endmodule

// File: rtl/dma_cost_calc.sv
// Cost calculator: picks one of four wait-state tables, looks up the source
// and destination regions in it, and adds the base cost and the first-unit
// surcharge for low regions.
// Assumes: NREG is a power of two and the region index is the top bits of
// the address.
module dma_cost_calc #(
    parameter int ADDR_W   = 28,
    parameter int NREG     = 16,
    parameter int WS_W     = 4,
    parameter int COST_W   = 6,
    parameter int CART_IDX = 8
) (
    input  logic [ADDR_W-1:0]    src_i,
    input  logic [ADDR_W-1:0]    dst_i,
    input  logic                 wide_i,
    input  logic                 first_i,
    input  logic [NREG*WS_W-1:0] ws_first16_i,
    input  logic [NREG*WS_W-1:0] ws_first32_i,
    input  logic [NREG*WS_W-1:0] ws_seq16_i,
    input  logic [NREG*WS_W-1:0] ws_seq32_i,
    output logic [COST_W-1:0]    cost_o
);

    localparam int REG_W = $clog2(NREG);

    logic [NREG*WS_W-1:0] table_sel;
    logic [WS_W-1:0]      ws_entry [NREG];
    logic [REG_W-1:0]     src_region;
    logic [REG_W-1:0]     dst_region;
    logic                 low_region;

    // Choose the table from the access kind and the width.
    always_comb begin
        if (first_i) begin
            table_sel = wide_i ? ws_first32_i : ws_first16_i;
        end else begin
            table_sel = wide_i ? ws_seq32_i : ws_seq16_i;
        end
    end

    // Split the selected table into one entry per region.
    for (genvar g = 0; g < NREG; g++) begin : g_unpack
        assign ws_entry[g] = table_sel[g*WS_W +: WS_W];
    end

    assign src_region = src_i[ADDR_W-1 -: REG_W];
    assign dst_region = dst_i[ADDR_W-1 -: REG_W];
    assign low_region = (src_region < REG_W'(CART_IDX)) || (dst_region < REG_W'(CART_IDX));

    // Add the base cost, both lookups and the first-unit surcharge.
    always_comb begin
        cost_o = COST_W'(2) + COST_W'(ws_entry[src_region]) + COST_W'(ws_entry[dst_region]);
        if (first_i && low_region) begin
            cost_o = cost_o + COST_W'(2);
        end
    end

endmodule

// File: rtl/dma_data_path.sv
// Data path: forms the write data from the read data and holds the last
// value moved. A halfword is copied into both halves.
// Assumes: memory returns a halfword in the low half of the read data.
module dma_data_path #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] rdata_i,
    input  logic              wide_i,
    input  logic              capture_i,
    output logic [DATA_W-1:0] wdata_o,
    output logic [DATA_W-1:0] latch_o
);

    localparam int HALF_W = DATA_W / 2;

    // Mirror the halfword for narrow units and pass the word for wide units.
    always_comb begin
        if (wide_i) begin
            wdata_o = rdata_i;
        end else begin
            wdata_o = {rdata_i[HALF_W-1:0], rdata_i[HALF_W-1:0]};
        end
    end

    // Hold the last value written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_o <= '0;
        end else if (capture_i) begin
            latch_o <= wdata_o;
        end
    end

endmodule

// File: rtl/dma_burst_seq.sv
// Burst sequencer top. It latches the channel settings on start, then runs
// read, write and wait phases for each unit until the count is used up, and
// ends with a one-cycle completion step.
// Assumes: read data is valid in the cycle after mem_rd, there is no bus
// back-pressure, and the costs fit in COST_W bits.
module dma_burst_seq
    import dma_seq_pkg::*;
#(
    parameter int ADDR_W   = 28,
    parameter int CNT_W    = 17,
    parameter int DATA_W   = 32,
    parameter int NREG     = 16,
    parameter int WS_W     = 4,
    parameter int CART_IDX = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ADDR_W-1:0]    src_addr,
    input  logic [ADDR_W-1:0]    dst_addr,
    input  logic [CNT_W-1:0]     unit_count,
    input  logic                 wide,
    input  logic [1:0]           src_step,
    input  logic [1:0]           dst_step,
    input  logic [NREG*WS_W-1:0] ws_first16,
    input  logic [NREG*WS_W-1:0] ws_first32,
    input  logic [NREG*WS_W-1:0] ws_seq16,
    input  logic [NREG*WS_W-1:0] ws_seq32,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 mem_rd,
    output logic                 mem_wr,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic                 mem_wide,
    output logic [DATA_W-1:0]    mem_wdata,
    output logic [DATA_W-1:0]    bus_latch,
    output logic                 busy,
    output logic                 done,
    output logic [ADDR_W-1:0]    cur_src,
    output logic [ADDR_W-1:0]    cur_dst,
    output logic [CNT_W-1:0]     cur_cnt
);

    localparam int COST_W = WS_W + 3;

    seq_state_t        state_q;
    logic [ADDR_W-1:0] src_q, dst_q, dst_base_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wide_q, first_q;
    logic [1:0]        sstep_q, dstep_q;
    logic [COST_W-1:0] wait_q;
    logic [COST_W-1:0] unit_cost;
    logic [ADDR_W-1:0] src_eff, src_next, dst_eff, dst_next;
    logic              last_unit;

    // Source and destination address units share one implementation.
    dma_addr_unit #(.ADDR_W(ADDR_W)) u_src_addr (
        .addr_i      (src_q),
        .mode_i      (sstep_q),
        .wide_i      (wide_q),
        .first_i     (first_q),
        .addr_eff_o  (src_eff),
        .addr_next_o (src_next)
    );

    dma_addr_unit #(.ADDR_W(ADDR_W)) u_dst_addr (
        .addr_i      (dst_q),
        .mode_i      (dstep_q),
        .wide_i      (wide_q),
        .first_i     (first_q),
        .addr_eff_o  (dst_eff),
        .addr_next_o (dst_next)
    );

    dma_cost_calc #(
        .ADDR_W   (ADDR_W),
        .NREG     (NREG),
        .WS_W     (WS_W),
        .COST_W   (COST_W),
        .CART_IDX (CART_IDX)
    ) u_cost (
        .src_i        (src_q),
        .dst_i        (dst_q),
        .wide_i       (wide_q),
        .first_i      (first_q),
        .ws_first16_i (ws_first16),
        .ws_first32_i (ws_first32),
        .ws_seq16_i   (ws_seq16),
        .ws_seq32_i   (ws_seq32),
        .cost_o       (unit_cost)
    );

    dma_data_path #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdata_i   (mem_rdata),
        .wide_i    (wide_q),
        .capture_i (mem_wr),
        .wdata_o   (mem_wdata),
        .latch_o   (bus_latch)
    );

    // The unit in its write phase is the last one when one unit remains.
    assign last_unit = (cnt_q == CNT_W'(1));

    // Sequence the phases and update the running settings.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            src_q      <= '0;
            dst_q      <= '0;
            dst_base_q <= '0;
            cnt_q      <= '0;
            wide_q     <= 1'b0;
            first_q    <= 1'b0;
            sstep_q    <= STEP_INC;
            dstep_q    <= STEP_INC;
            wait_q     <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        src_q      <= src_addr;
                        dst_q      <= dst_addr;
                        dst_base_q <= dst_addr;
                        cnt_q      <= unit_count;
                        wide_q     <= wide;
                        sstep_q    <= src_step;
                        dstep_q    <= dst_step;
                        first_q    <= 1'b1;
                        state_q    <= (unit_count == '0) ? ST_DONE : ST_READ;
                    end
                end
                ST_READ: begin
                    state_q <= ST_WRITE;
                end
                ST_WRITE: begin
                    src_q   <= src_next;
                    dst_q   <= dst_next;
                    cnt_q   <= cnt_q - CNT_W'(1);
                    first_q <= 1'b0;
                    if (unit_cost > COST_W'(2)) begin
                        wait_q  <= unit_cost - COST_W'(2);
                        state_q <= ST_WAIT;
                    end else begin
                        state_q <= last_unit ? ST_DONE : ST_READ;
                    end
                end
                ST_WAIT: begin
                    if (wait_q == COST_W'(1)) begin
                        state_q <= (cnt_q == '0) ? ST_DONE : ST_READ;
                    end else begin
                        wait_q <= wait_q - COST_W'(1);
                    end
                end
                ST_DONE: begin
                    if (dstep_q == STEP_RLD) begin
                        dst_q <= dst_base_q;
                    end
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the request and status outputs from the phase.
    always_comb begin
        mem_rd   = (state_q == ST_READ);
        mem_wr   = (state_q == ST_WRITE);
        mem_addr = (state_q == ST_WRITE) ? dst_eff : src_eff;
        mem_wide = wide_q;
        busy     = (state_q != ST_IDLE);
        done     = (state_q == ST_DONE);
        cur_src  = src_q;
        cur_dst  = dst_q;
        cur_cnt  = cnt_q;
    end

endmodule

// File: rtl/dma_seq_checker.sv
// Protocol checker for the burst sequencer, bound to every instance of it.
module dma_seq_checker #(
    parameter int CNT_W  = 17,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_wide,
    input logic [DATA_W-1:0] bus_latch,
    input logic              busy,
    input logic              done,
    input logic [CNT_W-1:0]  cur_cnt
);

    localparam int HALF_W = DATA_W / 2;

    assert_rd_wr_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_write_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> mem_wr);

    assert_halfword_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_wide) |=> (bus_latch[DATA_W-1:HALF_W] == bus_latch[HALF_W-1:0]));

    assert_access_inside_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> (busy && !done));

    assert_done_ends_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_count_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |=> (cur_cnt == CNT_W'($past(cur_cnt) - 1'b1)));

endmodule

bind dma_burst_seq dma_seq_checker #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wide  (mem_wide),
    .bus_latch (bus_latch),
    .busy      (busy),
    .done      (done),
    .cur_cnt   (cur_cnt)
);

// File: tb/sim_dma_burst_seq.sv
module sim_dma_burst_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [27:0] src_addr = '0, dst_addr = '0;
    logic [16:0] unit_count = '0;
    logic        wide = 1'b0;
    logic [1:0]  src_step = '0, dst_step = '0;
    logic [63:0] ws_first16, ws_first32, ws_seq16, ws_seq32;
    logic [31:0] mem_rdata = '0;
    logic        mem_rd, mem_wr, mem_wide, busy, done;
    logic [27:0] mem_addr, cur_src, cur_dst;
    logic [31:0] mem_wdata, bus_latch;
    logic [16:0] cur_cnt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int nrd = 0, nwr = 0, ndone = 0, done_cyc = 0;
    logic [27:0] rd_addr [64];
    int          rd_cyc  [64];
    logic [27:0] wr_addr [64];
    logic [31:0] wr_data [64];

    dma_burst_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
        .unit_count(unit_count), .wide(wide), .src_step(src_step), .dst_step(dst_step),
        .ws_first16(ws_first16), .ws_first32(ws_first32), .ws_seq16(ws_seq16), .ws_seq32(ws_seq32),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
        .mem_wide(mem_wide), .mem_wdata(mem_wdata), .bus_latch(bus_latch), .busy(busy),
        .done(done), .cur_src(cur_src), .cur_dst(cur_dst), .cur_cnt(cur_cnt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Wait-state tables, computed per region.
    function automatic logic [3:0] ws_of(input logic first, input logic w, input int r);
        if (first) return w ? 4'((r % 4) + 1) : 4'((r * 3) % 5);
        return w ? 4'((r % 2) + 2) : 4'(r % 3);
    endfunction

    // Memory content pattern as a function of address.
    function automatic logic [31:0] pattern(input logic [27:0] a);
        return {a[15:0] ^ 16'h5A3C, a[15:0] + 16'h1111};
    endfunction

    // Bus monitor and memory model, sampled away from the active edge.
    always @(negedge clk) begin
        if (mem_rd) begin
            rd_addr[nrd[5:0]] = mem_addr;
            rd_cyc[nrd[5:0]]  = cyc;
            nrd = nrd + 1;
            mem_rdata = mem_wide ? pattern(mem_addr) : {16'hBEEF, pattern(mem_addr)[15:0]};
        end
        if (mem_wr) begin
            wr_addr[nwr[5:0]] = mem_addr;
            wr_data[nwr[5:0]] = mem_wdata;
            nwr = nwr + 1;
        end
        if (done) begin
            ndone = ndone + 1;
            done_cyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done, "R1 busy/done in reset", {30'd0, busy, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_rd && !mem_wr, "R1 no access after reset", {30'd0, mem_rd, mem_wr}, 32'd0);
        chk(bus_latch == 32'd0, "R1 bus latch cleared", bus_latch, 32'd0);
        chk(!busy, "R1 idle after reset", {31'd0, busy}, 32'd0);
    endtask

    // Run one burst and compare every access against the cost model.
    task automatic run_burst(input logic [27:0] s_in, input logic [27:0] d_in, input int cnt,
                             input logic w, input logic [1:0] sm, input logic [1:0] dm, input bit poke);
        int t, c, guard, sr, dr, bytes;
        logic [27:0] s, d;
        logic [31:0] exp_data;
        logic first;
        nrd = 0; nwr = 0; ndone = 0;
        @(negedge clk);
        src_addr = s_in; dst_addr = d_in; unit_count = 17'(cnt);
        wide = w; src_step = sm; dst_step = dm; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = cyc;
        if (poke) begin
            repeat (2) @(negedge clk);
            src_addr = 28'h5000000; dst_addr = 28'h6000000; unit_count = 17'd7;
            wide = ~w; src_step = 2'd1; dst_step = 2'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (ndone == 0 && guard < 3000) begin
            @(negedge clk);
            guard++;
        end
        chk(ndone == 1, "R8 done seen", 32'(ndone), 32'd1);
        @(negedge clk);
        chk(!busy && !done, "R8 busy and done fall", {30'd0, busy, done}, 32'd0);
        bytes = w ? 4 : 2;
        s = s_in & (w ? ~28'd3 : ~28'd1);
        d = d_in & (w ? ~28'd3 : ~28'd1);
        first = 1'b1;
        exp_data = bus_latch;
        for (int u = 0; u < cnt; u++) begin
            sr = int'(s[27:24]); dr = int'(d[27:24]);
            c = 2 + int'(ws_of(first, w, sr)) + int'(ws_of(first, w, dr));
            if (first && (sr < 8 || dr < 8)) c = c + 2;
            chk(rd_addr[u] == s, "R3 R4 read address", 32'(rd_addr[u]), 32'(s));
            chk(wr_addr[u] == d, "R3 R4 write address", 32'(wr_addr[u]), 32'(d));
            chk(rd_cyc[u] == t, "R5 R6 read cycle", 32'(rd_cyc[u]), 32'(t));
            exp_data = w ? pattern(s) : {pattern(s)[15:0], pattern(s)[15:0]};
            chk(wr_data[u] == exp_data, "R7 write data", wr_data[u], exp_data);
            t = t + c;
            case (sm)
                2'd1: s = s - 28'(bytes);
                2'd2: s = s;
                default: s = s + 28'(bytes);
            endcase
            case (dm)
                2'd1: d = d - 28'(bytes);
                2'd2: d = d;
                default: d = d + 28'(bytes);
            endcase
            first = 1'b0;
        end
        chk(nrd == cnt && nwr == cnt, "R2 unit count of accesses", 32'(nrd), 32'(cnt));
        chk(done_cyc == t, "R5 R8 done cycle", 32'(done_cyc), 32'(t));
        if (cnt > 0) chk(bus_latch == exp_data, "R7 bus latch", bus_latch, exp_data);
        chk(cur_src == s, "R9 source write-back", 32'(cur_src), 32'(s));
        if (dm == 2'd3)
            chk(cur_dst == d_in, "R10 destination reload", 32'(cur_dst), 32'(d_in));
        else
            chk(cur_dst == d, "R9 destination write-back", 32'(cur_dst), 32'(d));
        chk(cur_cnt == 17'd0, "R9 count ends at zero", 32'(cur_cnt), 32'd0);
        if (poke) begin
            repeat (6) @(negedge clk);
            chk(nrd == cnt && ndone == 1 && !busy, "R12 start while busy ignored", 32'(nrd), 32'(cnt));
        end
    endtask

    task automatic test_zero_count();
        int t;
        nrd = 0; ndone = 0;
        @(negedge clk);
        unit_count = 17'd0; src_addr = 28'h2000000; dst_addr = 28'h3000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = cyc;
        chk(done, "R11 done right after start", {31'd0, done}, 32'd1);
        repeat (3) @(negedge clk);
        chk(nrd == 0 && ndone == 1, "R11 no access for zero count", 32'(nrd), 32'd0);
        chk(done_cyc == t, "R11 done cycle", 32'(done_cyc), 32'(t));
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            ws_first16[i*4 +: 4] = ws_of(1'b1, 1'b0, i);
            ws_first32[i*4 +: 4] = ws_of(1'b1, 1'b1, i);
            ws_seq16[i*4 +: 4]   = ws_of(1'b0, 1'b0, i);
            ws_seq32[i*4 +: 4]   = ws_of(1'b0, 1'b1, i);
        end
    end

    initial begin
        check_reset();
        run_burst(28'h2000100, 28'h3000200, 4, 1'b1, 2'd0, 2'd0, 1'b0);
        run_burst(28'h8000107, 28'h9000040, 3, 1'b0, 2'd1, 2'd2, 1'b0);
        run_burst(28'h8000012, 28'h3000020, 2, 1'b1, 2'd3, 2'd3, 1'b0);
        run_burst(28'h2000000, 28'h9000000, 3, 1'b0, 2'd2, 2'd0, 1'b1);
        run_burst(28'h8000400, 28'hA000000, 5, 1'b1, 2'd1, 2'd0, 1'b0);
        test_zero_count();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule